// File: doc/BRIEF.md
# Periodic pulse timing generator

The block produces a set of periodic pulse lines from one free-running 8-bit state counter. The counter visits all 256 states, so one frame lasts 256 enabled clocks. Each pulse channel has a start position and a stop position within the frame, both fixed when the design is elaborated. A channel has two match decoders of its own. The start match sets a registered output and the stop match clears it, so no output is ever taken straight from decode logic and the multi-bit counter steps cannot cause glitches.

The counter is built in one of two forms. The first is a plain binary counter. The second is a shift-register sequence counter with linear feedback, extended so that it also passes through the all-zero state, which makes its period 256 like the binary form. In the sequence form the decoders compare against the register state found at the requested position, not against the position number. Those states are worked out at elaboration by stepping the feedback sequence from the reset seed.

A channel can also be given a half-cycle stretch. A falling-edge stage then holds the pulse for half a clock after its clear. A registered frame strobe marks each return of the counter to position 0. The enable input freezes the counter and every output.

Top module: `pulse_timing_gen`

## Requirements
- R1: Positions count enabled clocks, starting at position 0 on the first enabled clock after reset. A channel's registered level goes high at the clock edge where the counter is at its start position and low at the edge where the counter is at its stop position. With the default start of 1 and stop of 4, the pulse is high for exactly 3 clocks and repeats every 256 enabled clocks.
- R2: The pulse width equals (stop − start) mod 256 clocks. When start is greater than stop, the pulse wraps across the frame boundary, and no pulse appears before the first time the counter reaches the start position after reset.
- R3: If the start and stop positions are equal, the clear wins and that channel never goes high.
- R4: In sequence-counter mode (MODE = 1), every output follows exactly the same timing as in binary mode (MODE = 0) for the same positions.
- R5: A channel whose STRETCH bit is set rises at the same time as it would without the stretch. Its fall is delayed until the next falling clock edge, so a pulse lasts half a clock longer.
- R6: frame_o goes high for one enabled clock after the edge at which the counter leaves position 255. It does not pulse during the first frame after reset.
- R7: While en is low, the counter, every pulse level and frame_o all hold their values.
- R8: An asserted rst_n clears every pulse output and frame_o at once. After release, the counter restarts at position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the levels update on the rising edge and the stretch stages on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Clock enable for the counter and all output flops |
| pulse_o | output | NUM_CH | Pulse lines, one per channel |
| frame_o | output | 1 | Frame strobe, high for one clock after each wrap to position 0 |

## Verification
Two cases are hard to reach from the ports. The first is a wrapping pulse, whose first appearance only comes in the second frame. The second is the half-clock stretch, which is only visible between the rising and falling edges. The bench runs a four-channel configuration through several full frames in both counter modes, which covers a normal window, a wrapped window, an equal start and stop, and a stretched channel. It samples each cycle once before and once after the falling edge. The expected levels come from the position arithmetic. Irregular enable gaps and a reset in the middle of a frame then confirm the hold behaviour and the restart.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  localparam int PTG_W   = 8;
  localparam int PTG_LEN = 1 << PTG_W;

  typedef logic [PTG_W-1:0] ptg_state_t;

  typedef enum logic {
    PTG_BINARY   = 1'b0,
    PTG_SEQUENCE = 1'b1
  } ptg_mode_e;

  // Feedback polynomial x^8+x^6+x^5+x^4+1, extended with the all-zero state.
  function automatic ptg_state_t seq_next(ptg_state_t s);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    fb = fb ^ (s[6:0] == 7'd0);
    return {s[6:0], fb};
  endfunction

  function automatic ptg_state_t reset_state(ptg_mode_e mode, ptg_state_t seed);
    return (mode == PTG_BINARY) ? '0 : seed;
  endfunction

  // State the counter holds at a given frame position.
  function automatic ptg_state_t state_at(ptg_mode_e mode, ptg_state_t seed,
                                          ptg_state_t pos);
    ptg_state_t s;
    s = reset_state(mode, seed);
    for (int i = 0; i < PTG_LEN; i++) begin
      if (i < int'(pos)) begin
        s = (mode == PTG_BINARY) ? s + ptg_state_t'(1) : seq_next(s);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/ptg_counter.sv
module ptg_counter
  import ptg_pkg::*;
#(
  parameter ptg_mode_e  MODE = PTG_BINARY,
  parameter ptg_state_t SEED = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output ptg_state_t state_q
);

  localparam ptg_state_t RST_ST = reset_state(MODE, SEED);

  ptg_state_t step_val;
  ptg_state_t state_d;

  generate
    if (MODE == PTG_BINARY) begin : g_binary
      always_comb step_val = state_q + ptg_state_t'(1);
    end else begin : g_sequence
      always_comb step_val = seq_next(state_q);
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (en) begin
      state_d = step_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RST_ST;
    end else if (en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/ptg_channel.sv
module ptg_channel
  import ptg_pkg::*;
#(
  parameter ptg_state_t START_ST = 8'h01,
  parameter ptg_state_t STOP_ST  = 8'h04,
  parameter bit         STRETCH  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  ptg_state_t state,
  output logic       level_q,
  output logic       pulse
);

  logic hit_set;
  logic hit_clr;
  logic level_d;

  always_comb begin
    hit_set = (state == START_ST);
    hit_clr = (state == STOP_ST);
    level_d = level_q;
    if (hit_clr) begin
      level_d = 1'b0;
    end else if (hit_set) begin
      level_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else if (en) begin
      level_q <= level_d;
    end
  end

  generate
    if (STRETCH) begin : g_stretch
      logic tail_q;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tail_q <= 1'b0;
        end else begin
          tail_q <= level_q;
        end
      end
      always_comb pulse = level_q | tail_q;
    end else begin : g_plain
      always_comb pulse = level_q;
    end
  endgenerate

endmodule

// File: rtl/ptg_frame.sv
module ptg_frame
  import ptg_pkg::*;
#(
  parameter ptg_state_t LAST_ST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  ptg_state_t state,
  output logic       frame_q
);

  logic frame_d;

  always_comb begin
    frame_d = frame_q;
    if (en) begin
      frame_d = (state == LAST_ST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
    end else if (en) begin
      frame_q <= frame_d;
    end
  end

endmodule

// File: rtl/pulse_timing_gen.sv
module pulse_timing_gen
  import ptg_pkg::*;
#(
  parameter int                         NUM_CH    = 1,
  parameter ptg_mode_e                  MODE      = PTG_BINARY,
  parameter ptg_state_t                 SEED      = 8'h01,
  parameter logic [NUM_CH*PTG_W-1:0]    START_POS = 8'd1,
  parameter logic [NUM_CH*PTG_W-1:0]    STOP_POS  = 8'd4,
  parameter logic [NUM_CH-1:0]          STRETCH   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [NUM_CH-1:0] pulse_o,
  output logic              frame_o
);

  localparam ptg_state_t LAST_POS = ptg_state_t'(PTG_LEN - 1);
  localparam ptg_state_t LAST_ST  = state_at(MODE, SEED, LAST_POS);

  ptg_state_t        state_q;
  logic [NUM_CH-1:0] lvl_q;

  ptg_counter #(
    .MODE (MODE),
    .SEED (SEED)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .state_q (state_q)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam ptg_state_t ST_ON  = state_at(MODE, SEED, START_POS[i*PTG_W +: PTG_W]);
      localparam ptg_state_t ST_OFF = state_at(MODE, SEED, STOP_POS[i*PTG_W +: PTG_W]);
      ptg_channel #(
        .START_ST (ST_ON),
        .STOP_ST  (ST_OFF),
        .STRETCH  (STRETCH[i])
      ) u_channel (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .state   (state_q),
        .level_q (lvl_q[i]),
        .pulse   (pulse_o[i])
      );
    end
  endgenerate

  ptg_frame #(
    .LAST_ST (LAST_ST)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .state   (state_q),
    .frame_q (frame_o)
  );

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
  import ptg_pkg::*;
#(
  parameter int                      NUM_CH    = 1,
  parameter logic [NUM_CH*PTG_W-1:0] START_POS = 8'd1,
  parameter logic [NUM_CH*PTG_W-1:0] STOP_POS  = 8'd4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [NUM_CH-1:0] lvl_q,
  input logic              frame_o
);

  logic [PTG_W:0] gap_cnt;
  logic           seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt    <= '0;
      seen_frame <= 1'b0;
    end else if (en) begin
      if (frame_o) begin
        gap_cnt    <= (PTG_W+1)'(1);
        seen_frame <= 1'b1;
      end else if (gap_cnt != '1) begin
        gap_cnt <= gap_cnt + (PTG_W+1)'(1);
      end
    end
  end

  // R1
  frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_o && seen_frame) |-> (gap_cnt == (PTG_W+1)'(PTG_LEN)));

  // R6
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_o) |=> !frame_o);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(lvl_q) && $stable(frame_o)));

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [PTG_W-1:0] WIDTH =
        STOP_POS[i*PTG_W +: PTG_W] - START_POS[i*PTG_W +: PTG_W];
      logic [PTG_W:0] wid_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wid_cnt <= '0;
        end else if (en) begin
          if (lvl_q[i]) begin
            wid_cnt <= wid_cnt + (PTG_W+1)'(1);
          end else begin
            wid_cnt <= '0;
          end
        end
      end

      if (WIDTH == '0) begin : g_never
        // R3
        never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !lvl_q[i]);
      end else begin : g_width
        // R2
        width_chk: assert property (@(posedge clk) disable iff (!rst_n)
          $fell(lvl_q[i]) |-> (wid_cnt == {1'b0, WIDTH}));
      end
    end
  endgenerate

endmodule

bind pulse_timing_gen ptg_checker #(
  .NUM_CH    (NUM_CH),
  .START_POS (START_POS),
  .STOP_POS  (STOP_POS)
) u_ptg_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .lvl_q   (lvl_q),
  .frame_o (frame_o)
);

// File: tb/pulse_timing_gen_bench.sv
`timescale 1ns/1ps
module pulse_timing_gen_bench;

  localparam int          NCH   = 4;
  localparam logic [31:0] B_ON  = {8'd100, 8'd10, 8'd250, 8'd1};
  localparam logic [31:0] B_OFF = {8'd140, 8'd10, 8'd5,   8'd4};
  localparam logic [3:0]  B_STR = 4'b1000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [NCH-1:0] pulse_b, pulse_s;
  logic           frame_b, frame_s;

  int checks = 0;
  int errors = 0;
  int n = 0;
  int n_neg = 0;
  int phase = 0;

  always #2 clk = ~clk;

  pulse_timing_gen #(
    .NUM_CH(NCH), .MODE(ptg_pkg::PTG_BINARY), .SEED(8'h01),
    .START_POS(B_ON), .STOP_POS(B_OFF), .STRETCH(B_STR)
  ) u_pulse_timing_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .pulse_o(pulse_b), .frame_o(frame_b)
  );

  pulse_timing_gen #(
    .NUM_CH(NCH), .MODE(ptg_pkg::PTG_SEQUENCE), .SEED(8'h5A),
    .START_POS(B_ON), .STOP_POS(B_OFF), .STRETCH(B_STR)
  ) u_pulse_timing_gen_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .pulse_o(pulse_s), .frame_o(frame_s)
  );

  function automatic logic lvl_model(int ch, int k);
    int q, s, e;
    if (k == 0) return 1'b0;
    q = (k - 1) % 256;
    s = int'(B_ON[ch*8 +: 8]);
    e = int'(B_OFF[ch*8 +: 8]);
    if (s == e) return 1'b0;
    if (s < e) return (q >= s) && (q < e);
    return (q >= s) || ((q < e) && (k >= 257));
  endfunction

  function automatic logic frame_model(int k);
    return (k > 0) && (k % 256 == 0);
  endfunction

  function automatic string tag_for(int ch);
    if (phase == 2) return "R7";
    if (phase == 4) return "R8";
    case (ch)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s n=%0d actual=%b expected=%b", req, what, n, act, exp);
    end
  endtask

  task automatic check_rise_half();
    logic e;
    for (int c = 0; c < NCH; c++) begin
      e = lvl_model(c, n);
      if (B_STR[c]) e = e | lvl_model(c, n_neg);
      chk(tag_for(c), $sformatf("binary ch%0d", c), pulse_b[c], e);
      // R4: sequence counter must match the same timing
      chk((phase == 1) ? "R4" : tag_for(c), $sformatf("sequence ch%0d", c), pulse_s[c], e);
    end
    chk(tag_for(4), "binary frame", frame_b, frame_model(n));
    chk((phase == 1) ? "R4" : tag_for(4), "sequence frame", frame_s, frame_model(n));
  endtask

  task automatic check_fall_half();
    // R5: after the falling edge the stretch has ended
    chk((phase == 2) ? "R7" : "R5", "binary ch3 late", pulse_b[3], lvl_model(3, n));
    chk((phase == 2) ? "R7" : "R5", "sequence ch3 late", pulse_s[3], lvl_model(3, n));
  endtask

  task automatic cycle(input logic en_next);
    @(posedge clk);
    if (en) n++;
    #1;
    check_rise_half();
    #2;
    check_fall_half();
    n_neg = n;
    en = en_next;
  endtask

  task automatic check_all_zero(string req);
    chk(req, "binary pulses clear", |pulse_b, 1'b0);
    chk(req, "sequence pulses clear", |pulse_s, 1'b0);
    chk(req, "binary frame clear", frame_b, 1'b0);
    chk(req, "sequence frame clear", frame_s, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state
    #9;
    check_all_zero("R8");
    rst_n = 1'b1;
    en = 1'b1;
    phase = 1;
    for (int i = 0; i < 700; i++) cycle(1'b1);
    // R7: irregular enable gaps
    phase = 2;
    for (int i = 0; i < 700; i++) cycle(!((i % 5 == 2) || (i % 11 == 0)));
    // R8: reset in the middle of a frame
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check_all_zero("R8");
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    n = 0;
    n_neg = 0;
    phase = 4;
    for (int i = 0; i < 300; i++) cycle(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule